// File: doc/BRIEF.md
# TFT Panel Video Timing Generator

This block produces the raster timing for a small portrait TFT panel that is 240 pixels wide and 320 lines tall. It drives horizontal sync, vertical sync, composite sync and blanking. It also reports a visible-area flag, the current column and row positions, and a one-cycle frame-start pulse. The panel timing is fixed by parameters, and each parameter is stored as its length minus one.

A line lasts 272 pixel periods, in this order: sync, back porch, visible area, front porch. A frame lasts 326 lines, in the same order. The block runs on the system clock. Its counters advance only on cycles where an internal pixel enable is high. That enable comes from a reloadable down-counter divider, which is bypassed when its reload value is zero or when its enable input is low.

A run input starts and stops the generator. While stopped, the counters are cleared and every sync and blank output sits at its inactive level. The inactive level follows that output's polarity bit. All the pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `tft_timing_gen`

## Requirements
- R1: While `run_en_i` is 0, `col_o` and `row_o` are 0 from the next clock edge onward, `visible_o` and `frame_start_o` are 0, and each sync/blank output equals its polarity bit (its inactive level).
- R2: The polarity bits are `pol_i[0]` for horizontal sync, `pol_i[1]` for vertical sync, `pol_i[2]` for composite sync and `pol_i[3]` for blanking. With the bit at 0 the output is high when active; with the bit at 1 it is low when active.
- R3: With `div_en_i` = 1 and `div_reload_i` = N > 0, the pixel enable fires once every N+1 system clocks. The column therefore advances once per N+1 clocks, and it first advances on the first edge after the run begins.
- R4: With `div_reload_i` = 0, or with `div_en_i` = 0, the pixel enable is high on every clock while running. The column then advances on every clock.
- R5: The counters change only on pixel-enable cycles. `col_o` counts 0 to 271 and then wraps to 0. `row_o` increments when the column wraps, and it counts 0 to 325 before wrapping to 0.
- R6: Horizontal sync is active for columns 0 to 4, which is 5 pixels.
- R7: Vertical sync is active for rows 0 and 1, which is 2 lines.
- R8: `visible_o` is 1 exactly for columns 26 to 265 within rows 4 to 323. Blanking is active whenever the position is outside that area.
- R9: Composite sync is active whenever horizontal sync or vertical sync is active.
- R10: `frame_start_o` is high for exactly one system clock, in the cycle after both counters wrap together to 0. It is not raised when the generator is started from the stopped state.
- R11: A synchronous reset `rst_i` clears both counters and restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_en_i | input | 1 | 1 runs the generator, 0 stops it |
| div_en_i | input | 1 | 1 allows clock division |
| div_reload_i | input | 8 | Divider reload value N (divide by N+1) |
| pol_i | input | 4 | Output polarity bits: [0] hsync, [1] vsync, [2] csync, [3] blank |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking |
| visible_o | output | 1 | Position is inside the visible area |
| col_o | output | 9 | Current pixel column |
| row_o | output | 9 | Current line |
| frame_start_o | output | 1 | One-cycle pulse at a frame wrap |

## Verification
The bench walks a whole frame and checks each cycle against an independent position model. A generator with an off-by-one in the stored-minus-one lengths would show a 4- or 6-pixel sync, a shifted visible window, or a 271- or 273-clock line. A vector table covers the reload and enable combinations, including reload zero while division is enabled. A divider that ignored the bypass would stall, or divide by 256 instead of passing every clock. Further checks switch the polarity in mid-frame and stop the generator, to catch outputs that stay active while stopped. They also confirm that no frame-start pulse appears when the generator starts from the stopped state.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;
  // Index of each sync/blank output in the polarity and output vectors
  typedef enum int {
    SIG_HSYNC = 0,
    SIG_VSYNC = 1,
    SIG_CSYNC = 2,
    SIG_BLANK = 3
  } sig_idx_e;

  localparam int NUM_SIG = 4;
endpackage

// File: rtl/tft_pix_div.sv
module tft_pix_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             pix_en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bypass;

  assign bypass = !div_en_i || (reload_i == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || bypass) cnt_q <= '0;
    else if (cnt_q == '0)          cnt_q <= reload_i;
    else                           cnt_q <= cnt_q - 1'b1;
  end

  assign pix_en_o = run_i && (bypass || (cnt_q == '0));

  // R3
  div_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_en_i && reload_i != '0 && pix_en_o) ##1 (run_i && div_en_i && reload_i != '0)
      |-> !pix_en_o);
endmodule

// File: rtl/tft_axis.sv
module tft_axis #(
  parameter int SYNC_M1 = 4,
  parameter int BP_M1   = 20,
  parameter int VIS_M1  = 239,
  parameter int TOTAL   = 272,
  parameter int W       = 9
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         run_i,
  input  logic         step_i,
  output logic [W-1:0] pos_o,
  output logic         wrap_o,
  output logic         sync_o,
  output logic         vis_o
);
  localparam int VIS_FIRST = SYNC_M1 + 1 + BP_M1 + 1;
  localparam int VIS_LAST  = VIS_FIRST + VIS_M1;

  logic [W-1:0] pos_q;
  logic         last;

  assign last = (pos_q == W'(TOTAL - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) pos_q <= '0;
    else if (step_i)     pos_q <= last ? '0 : pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign wrap_o = step_i && last;
  assign sync_o = (pos_q <= W'(SYNC_M1));
  assign vis_o  = (pos_q >= W'(VIS_FIRST)) && (pos_q <= W'(VIS_LAST));

  // R5
  pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pos_q < W'(TOTAL));

  // R5
  hold_no_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !step_i) |=> $stable(pos_q));
endmodule

// File: rtl/tft_sync_out.sv
module tft_sync_out #(
  parameter int N = 4
) (
  input  logic         run_i,
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] out_o
);
  for (genvar k = 0; k < N; k++) begin : g_pol
    assign out_o[k] = (run_i && act_i[k]) ^ pol_i[k];
  end
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int H_SYNC_M1 = 4,
  parameter int H_BP_M1   = 20,
  parameter int H_VIS_M1  = 239,
  parameter int H_TOTAL   = 272,
  parameter int V_SYNC_M1 = 1,
  parameter int V_BP_M1   = 1,
  parameter int V_VIS_M1  = 319,
  parameter int V_TOTAL   = 326,
  parameter int POS_W     = 9,
  parameter int DIV_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               run_en_i,
  input  logic               div_en_i,
  input  logic [DIV_W-1:0]   div_reload_i,
  input  logic [NUM_SIG-1:0] pol_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               csync_o,
  output logic               blank_o,
  output logic               visible_o,
  output logic [POS_W-1:0]   col_o,
  output logic [POS_W-1:0]   row_o,
  output logic               frame_start_o
);
  logic               pix_en;
  logic               h_wrap, v_wrap;
  logic               h_sync, v_sync, h_vis, v_vis;
  logic               frame_q;
  logic [NUM_SIG-1:0] act, outs;

  tft_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_en_i), .div_en_i(div_en_i),
    .reload_i(div_reload_i), .pix_en_o(pix_en)
  );

  tft_axis #(.SYNC_M1(H_SYNC_M1), .BP_M1(H_BP_M1), .VIS_M1(H_VIS_M1),
             .TOTAL(H_TOTAL), .W(POS_W)) u_h (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_en_i), .step_i(pix_en),
    .pos_o(col_o), .wrap_o(h_wrap), .sync_o(h_sync), .vis_o(h_vis)
  );

  tft_axis #(.SYNC_M1(V_SYNC_M1), .BP_M1(V_BP_M1), .VIS_M1(V_VIS_M1),
             .TOTAL(V_TOTAL), .W(POS_W)) u_v (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_en_i), .step_i(h_wrap),
    .pos_o(row_o), .wrap_o(v_wrap), .sync_o(v_sync), .vis_o(v_vis)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_en_i) frame_q <= 1'b0;
    else                    frame_q <= v_wrap;
  end

  always_comb begin
    act            = '0;
    act[SIG_HSYNC] = h_sync;
    act[SIG_VSYNC] = v_sync;
    act[SIG_CSYNC] = h_sync || v_sync;
    act[SIG_BLANK] = !(h_vis && v_vis);
  end

  tft_sync_out #(.N(NUM_SIG)) u_out (
    .run_i(run_en_i), .act_i(act), .pol_i(pol_i), .out_o(outs)
  );

  assign hsync_o       = outs[SIG_HSYNC];
  assign vsync_o       = outs[SIG_VSYNC];
  assign csync_o       = outs[SIG_CSYNC];
  assign blank_o       = outs[SIG_BLANK];
  assign visible_o     = run_en_i && h_vis && v_vis;
  assign frame_start_o = frame_q;

  // R1
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_en_i |=> (col_o == '0 && row_o == '0));

  // R10
  frame_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> (col_o == '0 && row_o == '0));

  // R10
  frame_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |=> !frame_start_o);
endmodule

// File: tb/tft_timing_gen_test.sv
`timescale 1ns/1ps
module tft_timing_gen_test;
  localparam int HT = 272;
  localparam int VT = 326;
  localparam int FRAME = HT * VT;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       run_en_i = 1'b0;
  logic       div_en_i = 1'b0;
  logic [7:0] div_reload_i = 8'd0;
  logic [3:0] pol_i = 4'd0;
  logic hsync_o, vsync_o, csync_o, blank_o, visible_o, frame_start_o;
  logic [8:0] col_o, row_o;

  int checks = 0;
  int errors = 0;
  int prints = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tft_timing_gen uut (
    .clk_i(clk), .rst_i(rst_i), .run_en_i(run_en_i), .div_en_i(div_en_i),
    .div_reload_i(div_reload_i), .pol_i(pol_i), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o),
    .visible_o(visible_o), .col_o(col_o), .row_o(row_o),
    .frame_start_o(frame_start_o)
  );

  // {div_en, reload, expected clocks per pixel}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'd5, 8'd1},
    {1'b1, 8'd0, 8'd1},
    {1'b1, 8'd1, 8'd2},
    {1'b1, 8'd2, 8'd3},
    {1'b1, 8'd7, 8'd8},
    {1'b0, 8'd0, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (prints < 20) begin
        prints++;
        $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_i = 1'b1;
    step();
    step();
    rst_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state, stopped, active-high polarity
    do_reset();
    chk(col_o == 0 && row_o == 0, "R11 reset position", {col_o, row_o}, 0);
    chk({hsync_o, vsync_o, csync_o, blank_o} == 4'b0000, "R1 stopped outputs pol=0",
        {hsync_o, vsync_o, csync_o, blank_o}, 0);
    chk(visible_o == 0 && frame_start_o == 0, "R1 stopped flags",
        {visible_o, frame_start_o}, 0);
    pol_i = 4'hF;
    #1;
    chk({blank_o, csync_o, vsync_o, hsync_o} == 4'hF, "R1 R2 stopped outputs pol=1",
        {blank_o, csync_o, vsync_o, hsync_o}, 15);
    pol_i = 4'h0;

    // Divider vectors: R3 / R4
    for (int k = 0; k < 6; k++) begin
      int n;
      bit fs_seen;
      do_reset();
      div_en_i = VEC[k][16];
      div_reload_i = VEC[k][15:8];
      run_en_i = 1'b1;
      fs_seen = 0;
      n = 0;
      while (col_o != 1 && n < 600) begin step(); n++; if (frame_start_o) fs_seen = 1; end
      chk(n == 1, "R3 R4 first advance", n, 1);
      n = 0;
      while (col_o != 2 && n < 600) begin step(); n++; if (frame_start_o) fs_seen = 1; end
      chk(n == int'(VEC[k][7:0]), VEC[k][7:0] == 8'd1 ? "R4 bypass period" : "R3 divided period",
          n, int'(VEC[k][7:0]));
      chk(!fs_seen, "R10 no pulse on start", fs_seen, 0);
      run_en_i = 1'b0;
      step();
    end

    // Mid-run reset: R11
    div_en_i = 1'b0;
    run_en_i = 1'b1;
    for (int i = 0; i < 30; i++) step();
    rst_i = 1'b1;
    step();
    rst_i = 1'b0;
    chk(col_o == 0 && row_o == 0, "R11 mid-run reset", col_o, 0);

    // Full-frame walk in bypass: R5..R10, R2 switch late
    run_en_i = 1'b0;
    step();
    run_en_i = 1'b1;
    #1;
    for (int i = 0; i <= FRAME + 300; i++) begin
      int eh, ev;
      bit hs, vs, cs, vis;
      bit [3:0] exp_o;
      if (i == FRAME + 100) begin pol_i = 4'hF; #1; end
      eh = i % HT;
      ev = (i / HT) % VT;
      hs = eh <= 4;
      vs = ev <= 1;
      cs = hs || vs;
      vis = (eh >= 26 && eh <= 265) && (ev >= 4 && ev <= 323);
      exp_o = {!vis, cs, vs, hs} ^ pol_i;
      chk(col_o == eh, "R5 column", col_o, eh);
      chk(row_o == ev, "R5 row", row_o, ev);
      chk(hsync_o == exp_o[0], "R6 R2 hsync", hsync_o, exp_o[0]);
      chk(vsync_o == exp_o[1], "R7 R2 vsync", vsync_o, exp_o[1]);
      chk(csync_o == exp_o[2], "R9 R2 csync", csync_o, exp_o[2]);
      chk(blank_o == exp_o[3], "R8 R2 blank", blank_o, exp_o[3]);
      chk(visible_o == vis, "R8 visible", visible_o, vis);
      chk(frame_start_o == (i == FRAME), "R10 frame start", frame_start_o, i == FRAME);
      step();
    end

    // Stop mid-frame with pol=1111: R1
    run_en_i = 1'b0;
    #1;
    chk({blank_o, csync_o, vsync_o, hsync_o} == 4'hF, "R1 stop outputs inactive",
        {blank_o, csync_o, vsync_o, hsync_o}, 15);
    step();
    chk(col_o == 0 && row_o == 0, "R1 stop clears counters", {col_o, row_o}, 0);
    chk(visible_o == 0 && frame_start_o == 0, "R1 stop flags", {visible_o, frame_start_o}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule